// File: doc/BRIEF.md
# Interrupt Pin Service and End-of-Interrupt Engine

This block decides when an interrupt input pin produces an injection request toward the processor side. It takes level-change events on individual pins and end-of-interrupt (EOI) notices that carry a vector. From these it tracks the present asserted state of every pin in a level bitmap, the remote-IRR bit of each level-triggered entry, and a separate coalescing flag for the periodic-tick pin (pin 8 by default). A tick consumer reads that flag to learn whether a tick was merged with an earlier one rather than delivered.

The per-pin configuration comes from the register block that sits beside this one, as flat input vectors: vector, destination, polarity, trigger mode and mask. Requests arrive one per cycle on a single request channel. An EOI starts a scan in which every pin still asserted is serviced again, in ascending order, one pin per cycle. This re-raises any level request that came in while the EOI was in flight. Each request's outcome and any injection appear on registered outputs one cycle after the request is accepted.

Top module: `irq_pin_service`

## Requirements
- R1: After reset the level bitmap, all remote-IRR bits and the tick flag are zero, no injection or result is signalled, and `reqReady` is high.
- R2: The effective line state of a pin is `reqLevel` XOR the pin's polarity bit, so polarity 1 means active-low.
- R3: An event whose effective state is deasserted clears the pin's bitmap bit, reports `resAccepted`=1 and does not inject.
- R4: An effective assertion on an edge-triggered pin (trigger bit 0) whose bitmap bit is already set changes nothing, reports `resAccepted`=0 and does not inject.
- R5: Any other effective assertion sets the pin's bitmap bit. If the pin's mask bit is 1, there is no injection and `resAccepted`=0.
- R6: An assertion on a level-triggered pin (trigger bit 1) whose remote-IRR is already set is coalesced: no injection, `resAccepted`=0.
- R7: While the tick flag is set, the tick pin does not inject. The request is coalesced with `resAccepted`=0.
- R8: When an assertion injects, `injValid` pulses for one cycle in the cycle after the request, carrying the pin number, its vector and its destination, with `resAccepted`=1. The injection sets the pin's remote-IRR if the pin is level-triggered; otherwise, if the pin is the tick pin, it sets the tick flag.
- R9: An EOI with vector V clears the tick flag if the tick pin's vector equals V, and clears the remote-IRR of every level-triggered pin whose vector equals V.
- R10: After an EOI, `reqReady` stays low for NPINS cycles while pins 0 to NPINS-1 are visited in ascending order, one per cycle. Each visited pin whose bitmap bit is set is serviced as an effective assertion (R4 to R8) without producing a result. At most one injection occurs per cycle.
- R11: An event for a pin number of NPINS or more raises `errPin` and `resValid` with `resAccepted`=0, does not inject, and leaves the bitmap, remote-IRR bits and tick flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present (taken only when `reqReady` is high) |
| reqIsEoi | input | 1 | 1: EOI request, 0: pin level event |
| reqPin | input | 5 | Pin number of a level event |
| reqLevel | input | 1 | Raw input level of a level event |
| reqVector | input | 8 | Vector carried by an EOI |
| reqReady | output | 1 | Low while the post-EOI scan runs |
| cfgVector | input | NPINS*8 | Vector of each pin, pin i at bits [8i+7:8i] |
| cfgDest | input | NPINS*8 | Destination of each pin, same layout |
| cfgPolarity | input | NPINS | Per-pin polarity, 1 = active-low |
| cfgLevel | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfgMask | input | NPINS | Per-pin mask, 1 = masked |
| injValid | output | 1 | Injection pulse |
| injPin | output | 5 | Pin being injected |
| injVector | output | 8 | Vector of the injected pin |
| injDest | output | 8 | Destination of the injected pin |
| resValid | output | 1 | Result of a level event is present |
| resAccepted | output | 1 | 1 = deasserted or injected, 0 = ignored, masked or coalesced |
| errPin | output | 1 | Level event named a pin out of range |
| levelBitmap | output | NPINS | Current effective level of each pin |
| remoteIrr | output | NPINS | Remote-IRR bit of each pin |
| tickFlag | output | 1 | Tick-pin coalescing flag |

## Verification
Directed sequences come first. One level pin is asserted, deasserted and asserted again before an EOI, then scanned back in. An edge pin gets repeated assertions. The bench also covers an active-low pin, a masked pin, repeated ticks on the tick pin, and an out-of-range pin number. These separate an injection from a coalesced request, an ignored one and a masked one. A seeded random phase follows. It mixes events on valid and invalid pins with EOIs whose vectors are drawn from a small pool, so that several entries share a vector. It also changes the configuration between requests. This exercises EOIs that clear several remote-IRR bits together, scans that re-inject several pins, and polarity and trigger-mode flips on pins that are already asserted.

// File: rtl/irq_pin_service_pkg.sv
package irq_pin_service_pkg;
  localparam int PIN_W = 5;
  localparam int VEC_W = 8;
  localparam int DST_W = 8;

  // strobes from control to datapath, one request per cycle
  typedef struct packed {
    logic             svc;     // service a pin
    logic             scan;    // service comes from the post-EOI scan
    logic             eoi;     // end-of-interrupt
    logic             bad;     // level event with out-of-range pin
    logic             lvl;     // raw input level of the event
    logic [PIN_W-1:0] pin;
    logic [VEC_W-1:0] vec;     // EOI vector
  } strobe_t;
endpackage

// File: rtl/irq_pin_service_ctrl.sv
module irq_pin_service_ctrl
  import irq_pin_service_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsEoi,
  input  logic [PIN_W-1:0] reqPin,
  input  logic             reqLevel,
  input  logic [VEC_W-1:0] reqVector,
  output logic             reqReady,
  output strobe_t          stb
);
  localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NPINS - 1);

  logic             scanning;
  logic [PIN_W-1:0] scanIdx;

  assign reqReady = !scanning;

  always_comb begin
    stb = '0;
    if (scanning) begin
      stb.svc  = 1'b1;
      stb.scan = 1'b1;
      stb.pin  = scanIdx;
    end else if (reqValid) begin
      if (reqIsEoi) begin
        stb.eoi = 1'b1;
        stb.vec = reqVector;
      end else if (int'(reqPin) >= NPINS) begin
        stb.bad = 1'b1;
      end else begin
        stb.svc = 1'b1;
        stb.pin = reqPin;
        stb.lvl = reqLevel;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanning <= 1'b0;
      scanIdx  <= '0;
    end else if (stb.eoi) begin
      scanning <= 1'b1;
      scanIdx  <= '0;
    end else if (scanning) begin
      if (scanIdx == LAST_PIN) scanning <= 1'b0;
      else scanIdx <= scanIdx + 1'b1;
    end
  end
endmodule

// File: rtl/irq_pin_service_dp.sv
module irq_pin_service_dp
  import irq_pin_service_pkg::*;
#(
  parameter int NPINS    = 24,
  parameter int TICK_PIN = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [NPINS*VEC_W-1:0] cfgVector,
  input  logic [NPINS*DST_W-1:0] cfgDest,
  input  logic [NPINS-1:0]       cfgPolarity,
  input  logic [NPINS-1:0]       cfgLevel,
  input  logic [NPINS-1:0]       cfgMask,
  output logic                   injValid,
  output logic [PIN_W-1:0]       injPin,
  output logic [VEC_W-1:0]       injVector,
  output logic [DST_W-1:0]       injDest,
  output logic                   resValid,
  output logic                   resAccepted,
  output logic                   errPin,
  output logic [NPINS-1:0]       levelBitmap,
  output logic [NPINS-1:0]       remoteIrr,
  output logic                   tickFlag
);
  logic [VEC_W-1:0] vecArr [NPINS];
  logic [DST_W-1:0] dstArr [NPINS];

  for (genvar g = 0; g < NPINS; g++) begin : g_unpack
    assign vecArr[g] = cfgVector[g*VEC_W +: VEC_W];
    assign dstArr[g] = cfgDest[g*DST_W +: DST_W];
  end

  logic             svcGo, effAsserted, isLevel, isTick;
  logic [NPINS-1:0] nBitmap, nRirr;
  logic             nTick, doInj, ok;

  assign isLevel     = cfgLevel[stb.pin];
  assign isTick      = (stb.pin == PIN_W'(TICK_PIN));
  assign svcGo       = stb.svc && (!stb.scan || levelBitmap[stb.pin]);
  assign effAsserted = stb.scan | (stb.lvl ^ cfgPolarity[stb.pin]);

  always_comb begin
    nBitmap = levelBitmap;
    nRirr   = remoteIrr;
    nTick   = tickFlag;
    doInj   = 1'b0;
    ok      = 1'b0;
    if (svcGo) begin
      if (!effAsserted) begin
        nBitmap[stb.pin] = 1'b0;
        ok = 1'b1;
      end else if (!(!isLevel && levelBitmap[stb.pin])) begin
        nBitmap[stb.pin] = 1'b1;
        if (!cfgMask[stb.pin] && !(isLevel && remoteIrr[stb.pin])
            && !(isTick && tickFlag)) begin
          doInj = 1'b1;
          ok    = 1'b1;
          if (isLevel) nRirr[stb.pin] = 1'b1;
          else if (isTick) nTick = 1'b1;
        end
      end
    end
    if (stb.eoi) begin
      if (vecArr[TICK_PIN] == stb.vec) nTick = 1'b0;
      for (int i = 0; i < NPINS; i++)
        if (cfgLevel[i] && vecArr[i] == stb.vec) nRirr[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelBitmap <= '0;
      remoteIrr   <= '0;
      tickFlag    <= 1'b0;
      injValid    <= 1'b0;
      injPin      <= '0;
      injVector   <= '0;
      injDest     <= '0;
      resValid    <= 1'b0;
      resAccepted <= 1'b0;
      errPin      <= 1'b0;
    end else begin
      levelBitmap <= nBitmap;
      remoteIrr   <= nRirr;
      tickFlag    <= nTick;
      injValid    <= doInj;
      if (doInj) begin
        injPin    <= stb.pin;
        injVector <= vecArr[stb.pin];
        injDest   <= dstArr[stb.pin];
      end
      resValid    <= (stb.svc && !stb.scan) || stb.bad;
      resAccepted <= ok && !stb.scan;
      errPin      <= stb.bad;
    end
  end
endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
  import irq_pin_service_pkg::*;
#(
  parameter int NPINS    = 24,
  parameter int TICK_PIN = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqIsEoi,
  input  logic [PIN_W-1:0]       reqPin,
  input  logic                   reqLevel,
  input  logic [VEC_W-1:0]       reqVector,
  output logic                   reqReady,
  input  logic [NPINS*VEC_W-1:0] cfgVector,
  input  logic [NPINS*DST_W-1:0] cfgDest,
  input  logic [NPINS-1:0]       cfgPolarity,
  input  logic [NPINS-1:0]       cfgLevel,
  input  logic [NPINS-1:0]       cfgMask,
  output logic                   injValid,
  output logic [PIN_W-1:0]       injPin,
  output logic [VEC_W-1:0]       injVector,
  output logic [DST_W-1:0]       injDest,
  output logic                   resValid,
  output logic                   resAccepted,
  output logic                   errPin,
  output logic [NPINS-1:0]       levelBitmap,
  output logic [NPINS-1:0]       remoteIrr,
  output logic                   tickFlag
);
  strobe_t stb;

  irq_pin_service_ctrl #(.NPINS(NPINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsEoi(reqIsEoi),
    .reqPin(reqPin), .reqLevel(reqLevel), .reqVector(reqVector),
    .reqReady(reqReady), .stb(stb)
  );

  irq_pin_service_dp #(.NPINS(NPINS), .TICK_PIN(TICK_PIN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgVector(cfgVector), .cfgDest(cfgDest),
    .cfgPolarity(cfgPolarity), .cfgLevel(cfgLevel), .cfgMask(cfgMask),
    .injValid(injValid), .injPin(injPin), .injVector(injVector), .injDest(injDest),
    .resValid(resValid), .resAccepted(resAccepted), .errPin(errPin),
    .levelBitmap(levelBitmap), .remoteIrr(remoteIrr), .tickFlag(tickFlag)
  );
endmodule

// File: rtl/irq_pin_service_chk.sv
module irq_pin_service_chk
  import irq_pin_service_pkg::*;
#(
  parameter int NPINS    = 24,
  parameter int TICK_PIN = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqIsEoi,
  input logic             reqReady,
  input logic             injValid,
  input logic [PIN_W-1:0] injPin,
  input logic             resValid,
  input logic             resAccepted,
  input logic             errPin,
  input logic [NPINS-1:0] levelBitmap,
  input logic [NPINS-1:0] remoteIrr,
  input logic             tickFlag
);
  AST_INJ_PIN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    injValid |-> levelBitmap[injPin]); // R8

  AST_RIRR_NEEDS_INJ: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(remoteIrr & ~$past(remoteIrr)) != 0) |-> injValid); // R8

  AST_BAD_PIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    errPin |-> (!injValid && resValid && !resAccepted
                && $stable(levelBitmap) && $stable(remoteIrr) && $stable(tickFlag))); // R11

  AST_EOI_STARTS_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqIsEoi) |=> !reqReady); // R10

  AST_SCAN_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> !resValid); // R10

  AST_TICK_RISE_INJ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tickFlag) |-> (injValid && injPin == PIN_W'(TICK_PIN))); // R7
endmodule

bind irq_pin_service irq_pin_service_chk #(.NPINS(NPINS), .TICK_PIN(TICK_PIN)) u_chk (.*);

// File: tb/tb_irq_pin_service.sv
module tb_irq_pin_service;
  localparam int NPINS = 24;
  localparam int TICK  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic                reqValid = 0, reqIsEoi = 0, reqLevel = 0;
  logic [4:0]          reqPin = '0;
  logic [7:0]          reqVector = '0;
  logic                reqReady;
  logic [NPINS*8-1:0]  cfgVector, cfgDest;
  logic [NPINS-1:0]    cfgPolarity, cfgLevel, cfgMask;
  logic                injValid, resValid, resAccepted, errPin, tickFlag;
  logic [4:0]          injPin;
  logic [7:0]          injVector, injDest;
  logic [NPINS-1:0]    levelBitmap, remoteIrr;

  logic [7:0] tVec [NPINS];
  logic [7:0] tDst [NPINS];
  logic [NPINS-1:0] tPol, tLvl, tMask;
  logic [NPINS-1:0] mBitmap, mRirr;
  logic mTick;

  int nChecks = 0, nFails = 0;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      cfgVector[i*8 +: 8] = tVec[i];
      cfgDest[i*8 +: 8]   = tDst[i];
    end
  end
  assign cfgPolarity = tPol;
  assign cfgLevel    = tLvl;
  assign cfgMask     = tMask;

  irq_pin_service dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsEoi(reqIsEoi), .reqPin(reqPin),
    .reqLevel(reqLevel), .reqVector(reqVector), .reqReady(reqReady),
    .cfgVector(cfgVector), .cfgDest(cfgDest), .cfgPolarity(cfgPolarity),
    .cfgLevel(cfgLevel), .cfgMask(cfgMask), .injValid(injValid), .injPin(injPin),
    .injVector(injVector), .injDest(injDest), .resValid(resValid),
    .resAccepted(resAccepted), .errPin(errPin), .levelBitmap(levelBitmap),
    .remoteIrr(remoteIrr), .tickFlag(tickFlag)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference service of one pin, returns whether it injected and the result bit
  task automatic mSvc(int p, bit lvl, bit scan, output bit inj, output bit ok);
    bit eff;
    inj = 0; ok = 0;
    if (scan && !mBitmap[p]) return;
    eff = scan ? 1'b1 : (lvl ^ tPol[p]);
    if (!eff) begin mBitmap[p] = 0; ok = 1; return; end
    if (!tLvl[p] && mBitmap[p]) return;
    mBitmap[p] = 1;
    if (tMask[p]) return;
    if (tLvl[p] && mRirr[p]) return;
    if (p == TICK && mTick) return;
    inj = 1; ok = 1;
    if (tLvl[p]) mRirr[p] = 1;
    else if (p == TICK) mTick = 1;
  endtask

  task automatic checkOut(string req, bit eInj, int ePin, bit eRes, bit eOk, bit eErr);
    check(req, "injValid", int'(injValid), int'(eInj));
    if (eInj) begin
      check(req, "injPin", int'(injPin), ePin);
      check(req, "injVector", int'(injVector), int'(tVec[ePin]));
      check(req, "injDest", int'(injDest), int'(tDst[ePin]));
    end
    check(req, "resValid", int'(resValid), int'(eRes));
    if (eRes) check(req, "resAccepted", int'(resAccepted), int'(eOk));
    check(req, "errPin", int'(errPin), int'(eErr));
    check(req, "levelBitmap", int'(levelBitmap), int'(mBitmap));
    check(req, "remoteIrr", int'(remoteIrr), int'(mRirr));
    check(req, "tickFlag", int'(tickFlag), int'(mTick));
  endtask

  // called at a negedge with inputs idle
  task automatic doEvent(string req, int p, bit lvl);
    bit inj, ok, bad;
    bad = (p >= NPINS);
    inj = 0; ok = 0;
    if (!bad) mSvc(p, lvl, 1'b0, inj, ok);
    reqValid = 1; reqIsEoi = 0; reqPin = 5'(p); reqLevel = lvl;
    @(negedge clk);
    reqValid = 0;
    checkOut(req, inj, p, 1'b1, ok, bad);
  endtask

  task automatic doEoi(string req, logic [7:0] v);
    bit inj, ok;
    if (tVec[TICK] == v) mTick = 0;
    for (int i = 0; i < NPINS; i++)
      if (tLvl[i] && tVec[i] == v) mRirr[i] = 0;
    reqValid = 1; reqIsEoi = 1; reqVector = v;
    @(negedge clk);
    reqValid = 0; reqIsEoi = 0;
    checkOut(req, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < NPINS; i++) begin
      check("R10", "reqReady during scan", int'(reqReady), 0);
      mSvc(i, 1'b1, 1'b1, inj, ok);
      @(negedge clk);
      checkOut("R10", inj, i, 1'b0, 1'b0, 1'b0);
    end
    check("R10", "reqReady after scan", int'(reqReady), 1);
  endtask

  task automatic setPin(int p, logic [7:0] v, bit pol, bit lvl, bit msk);
    tVec[p] = v; tPol[p] = pol; tLvl[p] = lvl; tMask[p] = msk;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NPINS; i++) begin
      tVec[i] = 8'h60 + 8'(i);
      tDst[i] = 8'($urandom);
    end
    tPol = '0; tLvl = '0; tMask = '1;
    mBitmap = '0; mRirr = '0; mTick = 0;

    repeat (3) @(negedge clk);
    check("R1", "levelBitmap", int'(levelBitmap), 0);
    check("R1", "remoteIrr", int'(remoteIrr), 0);
    check("R1", "tickFlag", int'(tickFlag), 0);
    check("R1", "injValid", int'(injValid), 0);
    check("R1", "resValid", int'(resValid), 0);
    rstN = 1;
    @(negedge clk);
    check("R1", "reqReady", int'(reqReady), 1);

    // level pin 23
    setPin(23, 8'h3A, 0, 1, 0);
    doEvent("R8", 23, 1);
    doEvent("R3", 23, 0);
    doEvent("R6", 23, 1);
    doEoi("R9", 8'h3A);           // scan re-injects pin 23 (R10)
    doEoi("R9", 8'h3A);
    // edge pin 5 repeated assertion
    setPin(5, 8'h41, 0, 0, 0);
    doEvent("R8", 5, 1);
    doEvent("R4", 5, 1);
    doEvent("R3", 5, 0);
    // active-low pin 2
    setPin(2, 8'h42, 1, 1, 0);
    doEvent("R2", 2, 0);
    doEvent("R2", 2, 1);
    // masked pin 3
    setPin(3, 8'h43, 0, 1, 1);
    doEvent("R5", 3, 1);
    // tick pin, edge triggered
    setPin(TICK, 8'h50, 0, 0, 0);
    doEvent("R8", TICK, 1);
    doEvent("R3", TICK, 0);
    doEvent("R7", TICK, 1);
    doEoi("R9", 8'h50);
    doEvent("R3", TICK, 0);
    doEvent("R7", TICK, 1);
    // out-of-range pins
    doEvent("R11", 24, 1);
    doEvent("R11", 31, 0);

    // seeded random phase with shared vectors
    for (int i = 0; i < NPINS; i++)
      setPin(i, 8'h30 + 8'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0));
    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r == 0) begin
        doEoi("R9", 8'h30 + 8'($urandom_range(0, 3)));
      end else if (r == 1) begin
        int p;
        p = $urandom_range(0, NPINS - 1);
        setPin(p, 8'h30 + 8'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0));
      end else begin
        doEvent("R8", $urandom_range(0, 27), 1'($urandom));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule